// File: doc/BRIEF.md
# Dual-Bank Bidirectional LCD Segment Driver Core

This block is the digital core of a dot-matrix LCD segment driver with 96 segments split into two independent banks of 48. Each bank holds a serial shift register whose direction is fixed by a strap input. The two end ports of a bank swap roles with that strap: one end takes serial data in and the other carries the bit about to leave, so several drivers can be chained. Each port is modelled as a separate input, output and output-enable.

The shift clock and the latch clock arrive as level signals. They are sampled on the core clock, and the core acts on their falling edges. A falling edge of the shift clock moves both banks by one position. A falling edge of the latch clock copies both shift registers into output latches. The latches hold while the next line is shifted in. Each latched bit combines with the alternation input to choose one of four drive levels, and the result appears as a 2-bit code for each segment. Reset is asynchronous and active low.

The serial data path is a plain strobed shift chain with no back-pressure, so no valid/ready handshake is used. A chained driver samples its upstream output on the same shift edge.

Top module: `lcdseg_driver`

## Requirements
- R1: Asynchronous active-low reset clears every shift register bit and every latch bit to 0. After reset with alternation 0, every segment code is 2'b01 and both port outputs of each bank read 0.
- R2: With a bank's direction input at 0, data enters at the left port and moves toward the higher segment numbers. After 48 shifts, the first bit shifted in sits at the bank's highest segment (48 or 96).
- R3: With a bank's direction input at 1, data enters at the right port and moves toward the lower segment numbers. After 48 shifts, the first bit shifted in sits at the bank's lowest segment (1 or 49).
- R4: A port's output-enable is 1 only when the direction makes that port the output: left enable = direction, right enable = inverted direction. The enabled output carries the bit at that end of the register, which is the bit about to be shifted out. A disabled output reads 0.
- R5: The shift registers move exactly one position for each falling edge of the shift clock, seen one core clock after the edge is sampled, and they hold otherwise. Both banks shift on the same edge.
- R6: A falling edge of the latch clock copies both full shift registers into the latches. The segment codes do not change from shifting while no latch edge occurs.
- R7: When latch and shift falling edges are sampled in the same core cycle, the latches receive the register contents from before that shift.
- R8: The segment code follows this encoding. Latched 1 gives 2'b00 with alternation 0 and 2'b11 with alternation 1. Latched 0 gives 2'b01 with alternation 0 and 2'b10 with alternation 1. The code follows the alternation input without a clock delay. Segment k (1..96) is at bits [2k-1:2k-2].
- R9: The two banks use their own direction and port inputs independently, and they may run in opposite directions at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Shift strobe; acts on its falling edge |
| latch_clk | input | 1 | Latch strobe; acts on its falling edge |
| alt_m | input | 1 | Drive polarity alternation |
| dir_a | input | 1 | Bank A direction (segments 1..48) |
| dir_b | input | 1 | Bank B direction (segments 49..96) |
| a_left_in | input | 1 | Bank A left port, input side |
| a_left_out | output | 1 | Bank A left port, output side |
| a_left_oe | output | 1 | Bank A left port output enable |
| a_right_in | input | 1 | Bank A right port, input side |
| a_right_out | output | 1 | Bank A right port, output side |
| a_right_oe | output | 1 | Bank A right port output enable |
| b_left_in | input | 1 | Bank B left port, input side |
| b_left_out | output | 1 | Bank B left port, output side |
| b_left_oe | output | 1 | Bank B left port output enable |
| b_right_in | input | 1 | Bank B right port, input side |
| b_right_out | output | 1 | Bank B right port, output side |
| b_right_oe | output | 1 | Bank B right port output enable |
| seg_level | output | 192 | 2-bit drive code per segment, segment 1 in the lowest bits |

## Verification
A latch edge and a shift edge can fall in the same core cycle, and the latch must then take the register contents from before the shift. The bench provokes this with directed and random steps that drop both strobes together in the middle of a line load. A reference model updates its latch copy before its shift copy, and the full set of segment codes is compared with that model right after the cycle.

// File: rtl/lcdseg_pkg.sv
`timescale 1ns/100ps
package lcdseg_pkg;

  typedef enum logic [1:0] {
    LVL_HI   = 2'b00,
    LVL_MIDH = 2'b01,
    LVL_MIDL = 2'b10,
    LVL_LO   = 2'b11
  } drive_lvl_e;

  // select one of four drive levels from latched bit and polarity
  function automatic drive_lvl_e pick_level(input logic on_bit, input logic alt);
    drive_lvl_e r;
    case ({on_bit, alt})
      2'b10:   r = LVL_HI;
      2'b11:   r = LVL_LO;
      2'b00:   r = LVL_MIDH;
      default: r = LVL_MIDL;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lcdseg_fall_det.sv
`timescale 1ns/100ps
module lcdseg_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_in;
  end

  assign fall_o = prev_q & ~level_in;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o) else $error("double fall strobe"); // R5

endmodule

// File: rtl/lcdseg_bank.sv
`timescale 1ns/100ps
module lcdseg_bank #(
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_fall,
  input  logic             latch_fall,
  input  logic             dir,
  input  logic             left_in,
  input  logic             right_in,
  output logic             left_out,
  output logic             left_oe,
  output logic             right_out,
  output logic             right_oe,
  output logic [WIDTH-1:0] lat_q
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_nxt;

  // per-cell neighbour selection, index 0 = lowest-numbered segment
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_lo_end
      assign from_low = left_in;
    end else begin : g_lo_mid
      assign from_low = sr_q[i-1];
    end
    if (i == TOP) begin : g_hi_end
      assign from_high = right_in;
    end else begin : g_hi_mid
      assign from_high = sr_q[i+1];
    end
    assign sr_nxt[i] = dir ? from_high : from_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sr_q <= '0;
    else if (shift_fall) sr_q <= sr_nxt;
  end

  // latch takes register contents before a coincident shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat_q <= '0;
    else if (latch_fall) lat_q <= sr_q;
  end

  assign left_oe   = dir;
  assign right_oe  = ~dir;
  assign left_out  = dir  & sr_q[0];
  assign right_out = ~dir & sr_q[TOP];

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_fall |=> $stable(sr_q)) else $error("register moved without strobe"); // R5

  AST_ENTRY_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fall && !dir) |=> sr_q[0] == $past(left_in)) else $error("left entry"); // R2

  AST_ENTRY_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fall && dir) |=> sr_q[TOP] == $past(right_in)) else $error("right entry"); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_fall |=> $stable(lat_q)) else $error("latch moved"); // R6

  AST_LATCH_PRESHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fall |=> lat_q == $past(sr_q)) else $error("latch capture"); // R7

endmodule

// File: rtl/lcdseg_drive.sv
`timescale 1ns/100ps
module lcdseg_drive
  import lcdseg_pkg::*;
#(
  parameter int SEGS = 96
) (
  input  logic [SEGS-1:0]   lat_bits,
  input  logic              alt,
  output logic [2*SEGS-1:0] level
);

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    drive_lvl_e lv;
    assign lv             = pick_level(lat_bits[s], alt);
    assign level[2*s +: 2] = lv;
  end

endmodule

// File: rtl/lcdseg_driver.sv
`timescale 1ns/100ps
module lcdseg_driver #(
  parameter int BANK_W = 48,
  localparam int SEG_N = 2 * BANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_clk,
  input  logic             latch_clk,
  input  logic             alt_m,
  input  logic             dir_a,
  input  logic             dir_b,
  input  logic             a_left_in,
  output logic             a_left_out,
  output logic             a_left_oe,
  input  logic             a_right_in,
  output logic             a_right_out,
  output logic             a_right_oe,
  input  logic             b_left_in,
  output logic             b_left_out,
  output logic             b_left_oe,
  input  logic             b_right_in,
  output logic             b_right_out,
  output logic             b_right_oe,
  output logic [2*SEG_N-1:0] seg_level
);

  logic              shift_fall;
  logic              latch_fall;
  logic [BANK_W-1:0] lat_a;
  logic [BANK_W-1:0] lat_b;

  lcdseg_fall_det u_shift_det (
    .clk(clk), .rst_n(rst_n), .level_in(shift_clk), .fall_o(shift_fall)
  );

  lcdseg_fall_det u_latch_det (
    .clk(clk), .rst_n(rst_n), .level_in(latch_clk), .fall_o(latch_fall)
  );

  lcdseg_bank #(.WIDTH(BANK_W)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .shift_fall(shift_fall), .latch_fall(latch_fall),
    .dir(dir_a), .left_in(a_left_in), .right_in(a_right_in),
    .left_out(a_left_out), .left_oe(a_left_oe),
    .right_out(a_right_out), .right_oe(a_right_oe), .lat_q(lat_a)
  );

  lcdseg_bank #(.WIDTH(BANK_W)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .shift_fall(shift_fall), .latch_fall(latch_fall),
    .dir(dir_b), .left_in(b_left_in), .right_in(b_right_in),
    .left_out(b_left_out), .left_oe(b_left_oe),
    .right_out(b_right_out), .right_oe(b_right_oe), .lat_q(lat_b)
  );

  lcdseg_drive #(.SEGS(SEG_N)) u_drive (
    .lat_bits({lat_b, lat_a}), .alt(alt_m), .level(seg_level)
  );

  AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!latch_fall) && $stable(alt_m)) |-> $stable(seg_level))
    else $error("segment code changed without latch"); // R6

  AST_PORT_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({a_left_oe, a_right_oe}) && $onehot({b_left_oe, b_right_oe}))
    else $error("port role"); // R4

endmodule

// File: tb/tb_lcdseg_driver.sv
`timescale 1ns/100ps
module tb_lcdseg_driver;

  localparam int W = 48;
  localparam int N = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_clk = 1'b1, latch_clk = 1'b1, alt_m = 1'b0;
  logic dir_a = 1'b0, dir_b = 1'b0;
  logic a_left_in = 1'b0, a_right_in = 1'b0, b_left_in = 1'b0, b_right_in = 1'b0;
  logic a_left_out, a_left_oe, a_right_out, a_right_oe;
  logic b_left_out, b_left_oe, b_right_out, b_right_oe;
  logic [2*N-1:0] seg_level;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] sr_a = '0, sr_b = '0, lt_a = '0, lt_b = '0;

  always #2.5 clk = ~clk;

  lcdseg_driver dut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .latch_clk(latch_clk),
    .alt_m(alt_m), .dir_a(dir_a), .dir_b(dir_b),
    .a_left_in(a_left_in), .a_left_out(a_left_out), .a_left_oe(a_left_oe),
    .a_right_in(a_right_in), .a_right_out(a_right_out), .a_right_oe(a_right_oe),
    .b_left_in(b_left_in), .b_left_out(b_left_out), .b_left_oe(b_left_oe),
    .b_right_in(b_right_in), .b_right_out(b_right_out), .b_right_oe(b_right_oe),
    .seg_level(seg_level)
  );

  function automatic logic [1:0] exp_code(input logic b, input logic m);
    if (b) return m ? 2'b11 : 2'b00;
    return m ? 2'b10 : 2'b01;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_levels(input string req);
    int bad_seg;
    logic [1:0] e, a;
    bad_seg = -1;
    e = 2'b00; a = 2'b00;
    for (int i = 0; i < N; i++) begin
      logic bt;
      bt = (i < W) ? lt_a[i] : lt_b[i-W];
      if (bad_seg < 0 && seg_level[2*i +: 2] !== exp_code(bt, alt_m)) begin
        bad_seg = i;
        e = exp_code(bt, alt_m);
        a = seg_level[2*i +: 2];
      end
    end
    n_chk++;
    if (bad_seg >= 0) begin
      n_bad++;
      $display("FAIL %s segment %0d actual=%0b expected=%0b", req, bad_seg + 1, a, e);
    end
  endtask

  task automatic check_ports();
    check("R4 a_left_oe", 32'(a_left_oe), 32'(dir_a));
    check("R4 a_right_oe", 32'(a_right_oe), 32'(!dir_a));
    check("R4 b_left_oe", 32'(b_left_oe), 32'(dir_b));
    check("R4 b_right_oe", 32'(b_right_oe), 32'(!dir_b));
    check("R4 a_left_out", 32'(a_left_out), 32'(dir_a ? sr_a[0] : 1'b0));
    check("R4 a_right_out", 32'(a_right_out), 32'(dir_a ? 1'b0 : sr_a[W-1]));
    check("R4 b_left_out", 32'(b_left_out), 32'(dir_b ? sr_b[0] : 1'b0));
    check("R4 b_right_out", 32'(b_right_out), 32'(dir_b ? 1'b0 : sr_b[W-1]));
  endtask

  // one strobe cycle: drop selected strobes, then raise them again
  task automatic step(input logic sh, input logic la, input logic [3:0] d);
    @(negedge clk);
    {a_left_in, a_right_in, b_left_in, b_right_in} = d;
    shift_clk = !sh;
    latch_clk = !la;
    @(negedge clk);
    shift_clk = 1'b1;
    latch_clk = 1'b1;
    if (la) begin lt_a = sr_a; lt_b = sr_b; end
    if (sh) begin
      sr_a = dir_a ? {d[2], sr_a[W-1:1]} : {sr_a[W-2:0], d[3]};
      sr_b = dir_b ? {d[0], sr_b[W-1:1]} : {sr_b[W-2:0], d[1]};
    end
    check_ports();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int unused;
    unused = $urandom(32'h5E6D_0021);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check_levels("R1 reset levels");
    check("R1 a_right_out", 32'(a_right_out), 32'd0);
    check("R1 b_right_out", 32'(b_right_out), 32'd0);
    check_ports();

    // R2 R3 R9 directed marker walk for every direction pair
    for (int c = 0; c < 4; c++) begin
      dir_a = c[0];
      dir_b = c[1];
      idle(1);
      step(1'b1, 1'b0, 4'hF);
      for (int k = 1; k < W; k++) step(1'b1, 1'b0, 4'h0);
      step(1'b0, 1'b1, 4'h0);
      alt_m = 1'b0;
      #1;
      check_levels("R9 marker model");
      check(dir_a ? "R3 bank a seg1" : "R2 bank a seg48",
            32'(seg_level[2*(dir_a ? 0 : W-1) +: 2]), 32'd0);
      check(dir_b ? "R3 bank b seg49" : "R2 bank b seg96",
            32'(seg_level[2*(dir_b ? W : N-1) +: 2]), 32'd0);
      check(dir_a ? "R3 bank a seg48 clear" : "R2 bank a seg1 clear",
            32'(seg_level[2*(dir_a ? W-1 : 0) +: 2]), 32'd1);
    end

    // R8 polarity toggle without latch
    alt_m = 1'b1;
    #1;
    check_levels("R8 alt high");
    alt_m = 1'b0;
    #1;
    check_levels("R8 alt low");

    // R6 shifting without latch leaves codes alone
    for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 4'(k));
    check_levels("R6 hold while shifting");

    // R7 directed coincidence
    step(1'b1, 1'b1, 4'hA);
    check_levels("R7 coincident latch");
    step(1'b0, 1'b1, 4'h0);
    check_levels("R7 following latch");

    // random lines, directions, polarity, with coincident strobes mixed in
    for (int line = 0; line < 16; line++) begin
      idle(1);
      dir_a = 1'($urandom);
      dir_b = 1'($urandom);
      for (int k = 0; k < W; k++) begin
        logic la;
        la = ($urandom % 10) == 0;
        step(1'b1, la, 4'($urandom));
        if (la) check_levels("R7 random coincident latch");
        else if (k % 12 == 5) check_levels("R6 random hold");
      end
      step(1'b0, 1'b1, 4'h0);
      alt_m = 1'($urandom);
      #1;
      check_levels("R5 random line latched");
      if ($urandom % 3 == 0) begin
        step(1'b0, 1'b0, 4'hF);
        check_levels("R5 no strobe no change");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule